// File: doc/BRIEF.md
# Synchronised Power-Down Clock Gate

This block sits between a set of free-running clock sources and the pins or loads they feed. It stops those clocks cleanly in two situations: when an asynchronous, active-low power-down request arrives, and when a per-output enable bit from the configuration registers is cleared. A stopped output is held low. The block never truncates a high phase, so no runt pulse leaves it.

The power-down request is synchronised into the CPU clock domain. A filter then requires the synchronised level to agree on two consecutive CPU rising edges before the block changes mode. Entering power-down raises a PLL-off request for the analog section. Leaving power-down drops that request. Each output has its own enable register, clocked on the falling edge of that output's own source. As a result, an output can start or stop only while its source is low: the last pulse before a stop and the first pulse after a restart are both full width.

Top module: `clk_pd_gate`

## Requirements
- R1: While rst_ni is low, pll_off_o is 0 and every clk_o bit is 0.
- R2: When pwr_dn_ni falls between two CPU edges and stays low, pll_off_o rises on the (SYNC_STAGES+2)-th CPU rising edge after the fall. This is the 4th edge with SYNC_STAGES=2.
- R3: A low pulse on pwr_dn_ni that covers only one CPU rising edge does not enter power-down, and the outputs keep toggling.
- R4: On entry, an output whose source is high at the entry edge completes that high phase. It is low from the next falling edge of its source.
- R5: While in power-down, every clk_o bit stays 0 whatever the value of clk_en_i.
- R6: When pwr_dn_ni rises between two CPU edges and stays high, pll_off_o falls on the (SYNC_STAGES+2)-th CPU rising edge after the rise.
- R7: On exit, an enabled output stays low for the rest of the current phase of its source. Its first pulse begins on the next rising edge of the source after a falling edge.
- R8: Bit k of clk_en_i controls clk_o[k] only: 1 passes src_clk_i[k], and 0 holds clk_o[k] at 0.
- R9: Every high pulse on clk_o[k] is exactly as wide as the high phase of src_clk_i[k], including pulses next to enable changes at arbitrary times.
- R10: pll_off_o is 1 exactly while the block is in power-down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | CPU clock used to sample the power-down request |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_dn_ni | input | 1 | Asynchronous active-low power-down request |
| src_clk_i | input | N_CLK | Free-running source clocks, one per output |
| clk_en_i | input | N_CLK | Per-output enable from the configuration registers, 1 = run |
| clk_o | output | N_CLK | Gated clock outputs |
| pll_off_o | output | 1 | PLL shutdown request, high while in power-down |

## Verification
The bench uses the defaults N_CLK=4 and SYNC_STAGES=2. It feeds the four sources at the CPU rate twice, at half rate and at quarter rate. With these sources, the falling edges that retire each enable land on different CPU cycles relative to the mode change. This exposes per-output independence and the wait for each source's own falling edge. The two-stage synchroniser keeps the entry and exit latency at four CPU edges, so the single-edge glitch case and the exact switching cycle can be observed.

// File: rtl/clk_pd_gate_pkg.sv
`timescale 1ns/1ps
package clk_pd_gate_pkg;
  typedef enum logic {
    PD_RUN = 1'b0,
    PD_OFF = 1'b1
  } pd_state_e;
endpackage

// File: rtl/pdg_sync.sv
`timescale 1ns/1ps
module pdg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES <= 1) begin : g_single
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= RST_VAL;
        else         q <= d_i;
      assign q_o = q;
    end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= {STAGES{RST_VAL}};
        else         q <= {q[STAGES-2:0], d_i};
      assign q_o = q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/pdg_filter.sv
`timescale 1ns/1ps
module pdg_filter
  import clk_pd_gate_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_n_i,   // synchronised, active low
  output pd_state_e state_o
);
  logic      prev_q;
  pd_state_e state_q, state_d;

  // mode flips only when two consecutive samples agree
  always_comb begin
    state_d = state_q;
    if (!req_n_i && !prev_q)     state_d = PD_OFF;
    else if (req_n_i && prev_q)  state_d = PD_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      prev_q  <= 1'b1;
      state_q <= PD_RUN;
    end else begin
      prev_q  <= req_n_i;
      state_q <= state_d;
    end

  assign state_o = state_q;
endmodule

// File: rtl/pdg_gate_cell.sv
`timescale 1ns/1ps
module pdg_gate_cell (
  input  logic src_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic clk_o
);
  logic en_q;

  // enable moves only while the source is low
  always_ff @(negedge src_i or negedge rst_ni)
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= run_i;

  assign clk_o = src_i & en_q;
endmodule

// File: rtl/clk_pd_gate.sv
`timescale 1ns/1ps
module clk_pd_gate
  import clk_pd_gate_pkg::*;
#(
  parameter int N_CLK       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_dn_ni,
  input  logic [N_CLK-1:0] src_clk_i,
  input  logic [N_CLK-1:0] clk_en_i,
  output logic [N_CLK-1:0] clk_o,
  output logic             pll_off_o
);
  logic      req_n_sync;
  pd_state_e pd_state;

  pdg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pwr_dn_ni),
    .q_o    (req_n_sync)
  );

  pdg_filter u_filter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_n_i (req_n_sync),
    .state_o (pd_state)
  );

  assign pll_off_o = (pd_state == PD_OFF);

  for (genvar k = 0; k < N_CLK; k++) begin : g_gate
    pdg_gate_cell u_cell (
      .src_i  (src_clk_i[k]),
      .rst_ni (rst_ni),
      .run_i  (clk_en_i[k] & ~pll_off_o),
      .clk_o  (clk_o[k])
    );
  end
endmodule

// File: rtl/clk_pd_gate_chk.sv
`timescale 1ns/1ps
module clk_pd_gate_chk #(
  parameter int N_CLK = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pwr_dn_ni,
  input logic [N_CLK-1:0] clk_en_i,
  input logic [N_CLK-1:0] clk_o,
  input logic             pll_off_o
);
  AST_PD_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pll_off_o) |-> (!$past(pwr_dn_ni, 1) && !$past(pwr_dn_ni, 2))); // R2
  AST_PD_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pll_off_o) |-> ($past(pwr_dn_ni, 1) && $past(pwr_dn_ni, 2)));  // R6
  // sources are assumed to fall at least once every four CPU cycles
  AST_PD_ALL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pll_off_o && $past(pll_off_o, 1) && $past(pll_off_o, 2) && $past(pll_off_o, 3)
     && $past(pll_off_o, 4)) |-> (clk_o == '0));                         // R5

  for (genvar k = 0; k < N_CLK; k++) begin : g_bit
    AST_CFG_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clk_en_i[k] && !$past(clk_en_i[k], 1) && !$past(clk_en_i[k], 2)
       && !$past(clk_en_i[k], 3) && !$past(clk_en_i[k], 4) && !$past(clk_en_i[k], 5))
      |-> !clk_o[k]);                                                    // R8
  end
endmodule

bind clk_pd_gate clk_pd_gate_chk #(.N_CLK(N_CLK)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pwr_dn_ni (pwr_dn_ni),
  .clk_en_i  (clk_en_i),
  .clk_o     (clk_o),
  .pll_off_o (pll_off_o)
);

// File: tb/clk_pd_gate_bench.sv
`timescale 1ns/1ps
module clk_pd_gate_bench;
  localparam int N   = 4;
  localparam int WIN = 16;
  localparam real HALF = 2.5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_dn_n = 1'b1;
  logic [N-1:0] cfg = '1;
  logic [1:0] div = 2'b00;
  logic [N-1:0] src;
  logic [N-1:0] gclk;
  logic pll_off;

  int checks = 0;
  int fails  = 0;
  bit counting = 1'b0;
  int cnt  [N];
  int runt [N];

  always #(HALF) clk = ~clk;
  always @(posedge clk) div <= div + 2'd1;
  assign src = {div[1], div[0], clk, clk};

  clk_pd_gate #(.N_CLK(N), .SYNC_STAGES(2)) u_clk_pd_gate (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .pwr_dn_ni (pwr_dn_n),
    .src_clk_i (src),
    .clk_en_i  (cfg),
    .clk_o     (gclk),
    .pll_off_o (pll_off)
  );

  function automatic int src_div(int k);
    return (k == 2) ? 2 : (k == 3) ? 4 : 1;
  endfunction

  function automatic int exp_edges(int k, logic [N-1:0] en, bit pd);
    return (pd || !en[k]) ? 0 : WIN / src_div(k);
  endfunction

  // pulse width monitor: every high pulse must equal the source high phase
  for (genvar g = 0; g < N; g++) begin : g_mon
    realtime t_rise;
    always @(posedge gclk[g]) begin
      t_rise = $realtime;
      if (counting) cnt[g]++;
    end
    always @(negedge gclk[g]) begin
      if (rst_n) begin
        realtime w;
        w = $realtime - t_rise;
        if (w < HALF * src_div(g) - 0.01 || w > HALF * src_div(g) + 0.01) runt[g]++;
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edge1();
    @(posedge clk);
    #1;
  endtask

  task automatic measure(string req, bit pd);
    for (int k = 0; k < N; k++) cnt[k] = 0;
    counting = 1'b1;
    repeat (WIN) @(posedge clk);
    #1;
    counting = 1'b0;
    for (int k = 0; k < N; k++)
      check(cnt[k] == exp_edges(k, cfg, pd), req, cnt[k], exp_edges(k, cfg, pd));
  endtask

  initial begin
    #(200000 * 2 * HALF);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) begin cnt[k] = 0; runt[k] = 0; end
    void'($urandom(32'h5eed_c10c));

    // R1: reset state
    repeat (3) edge1();
    check(pll_off == 1'b0, "R1 pll_off in reset", pll_off, 0);
    check(gclk == '0, "R1 outputs in reset", gclk, 0);
    rst_n = 1'b1;
    repeat (8) edge1();

    // R8: enables pass or hold each output
    measure("R8 all enabled", 1'b0);
    cfg = 4'b0000; repeat (8) edge1(); measure("R8 all disabled", 1'b0);
    cfg = 4'b1010; repeat (8) edge1(); measure("R8 pattern 1010", 1'b0);
    for (int i = 0; i < 6; i++) begin
      cfg = N'($urandom());
      repeat (8) edge1();
      measure("R8 random enables", 1'b0);
    end

    // R9: enable flips at arbitrary times never cut a pulse
    for (int i = 0; i < 24; i++) begin
      #($urandom_range(1, 9));
      cfg = N'($urandom());
    end
    cfg = '1;
    repeat (8) edge1();

    // R3: single-edge glitch is filtered
    begin
      bit seen = 1'b0;
      pwr_dn_n = 1'b0;
      edge1();
      pwr_dn_n = 1'b1;
      for (int i = 0; i < 8; i++) begin
        edge1();
        if (pll_off) seen = 1'b1;
      end
      check(!seen, "R3 glitch ignored", seen, 0);
    end
    measure("R3 outputs still running", 1'b0);

    // R2 R4 R10: entry timing
    edge1();
    pwr_dn_n = 1'b0;
    repeat (3) edge1();
    check(pll_off == 1'b0, "R2 no entry before 4th edge", pll_off, 0);
    edge1();
    check(pll_off == 1'b1, "R2 R10 entry on 4th edge", pll_off, 1);
    check(gclk[0] == 1'b1, "R4 last pulse completes", gclk[0], 1);
    edge1();
    check(gclk[0] == 1'b0, "R4 stopped after falling edge", gclk[0], 0);
    repeat (6) edge1();

    // R5: outputs low in power-down regardless of enables
    measure("R5 all low in power-down", 1'b1);
    cfg = 4'b0110; repeat (2) edge1(); cfg = '1;
    measure("R5 enable changes ignored", 1'b1);

    // R6 R7 R10: exit timing, bit 1 kept disabled
    cfg = 4'b1101;
    edge1();
    pwr_dn_n = 1'b1;
    repeat (3) edge1();
    check(pll_off == 1'b1, "R6 no exit before 4th edge", pll_off, 1);
    edge1();
    check(pll_off == 1'b0, "R6 R10 exit on 4th edge", pll_off, 0);
    check(gclk[0] == 1'b0, "R7 no partial pulse at exit", gclk[0], 0);
    edge1();
    check(gclk[0] == 1'b1, "R7 resumes after falling edge", gclk[0], 1);
    repeat (6) edge1();
    measure("R7 R8 outputs after exit", 1'b0);

    for (int k = 0; k < N; k++)
      check(runt[k] == 0, "R9 no runt pulse", runt[k], 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule